// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Level-One Read Cache

This block is a 16 KB, four-way set-associative read cache that sits between a load pipeline and a next-level memory. A request brings only the page-offset bits of the virtual address. Set selection and the array read start from those bits at once, because the set index and the line offset lie wholly inside the 12-bit page offset and so are the same in the virtual and the physical address. The physical page number arrives from a separate translator one cycle after acceptance, or later, with its own valid strobe. The stored 20-bit tags of the selected set are then compared against it.

A hit returns the addressed 32-bit word in the cycle after the page number arrives. A miss sends a line-aligned physical address to the next level and collects eight 32-bit beats. It writes the line into a victim way, which is an invalid way if one exists and otherwise a tree pseudo-LRU choice. It then answers the waiting request from the new line. The controller has five named states: ST_IDLE (ready for a request), ST_LOOKUP (waiting for the page number and comparing tags), ST_MISS_REQ (holding the miss request), ST_FILL (counting fill beats) and ST_REPLAY (writing the line and answering). The transitions are accept (ST_IDLE to ST_LOOKUP), hit (ST_LOOKUP to ST_IDLE), miss (ST_LOOKUP to ST_MISS_REQ), grant (ST_MISS_REQ to ST_FILL), last beat (ST_FILL to ST_REPLAY) and done (ST_REPLAY to ST_IDLE). A global invalidate input drops every line.

Top module: `vipt_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req_valid are 0, and every line is invalid, so the first access misses.
- R2: The set is req_vword[11:5] (virtual address bits 11:5) and the word within the line is req_vword[4:2]. A hit needs a valid way whose stored tag equals xlat_ppn, regardless of the virtual page, and at most one way matches.
- R3: On a hit, resp_valid is high for one cycle in the cycle after the cycle in which xlat_valid is sampled. resp_data is the addressed word, and no miss request is made.
- R4: While xlat_valid stays low in ST_LOOKUP, neither resp_valid nor mem_req_valid is raised.
- R5: A miss raises mem_req_valid with mem_req_addr = {ppn, set, 5'b0} and holds both until mem_req_ready is sampled high.
- R6: A fill takes exactly eight fill_valid beats, and beat k is word k of the line. The response follows from the filled line with the word selected by R2.
- R7: req_ready is low from acceptance until the response cycle. A req_valid pulse while req_ready is low is ignored and causes no response or miss request.
- R8: On a miss, the lowest-numbered invalid way of the set is filled, so four distinct pages in one set all stay resident.
- R9: When all ways are valid, the victim is taken from a 3-bit tree per set. The root bit picks the pair (0 = ways 0/1, 1 = ways 2/3) and a leaf bit picks within the pair (0 = lower way). Every hit or fill to a way points the bits on its path away from it.
- R10: A one-cycle pulse on inval_all clears every valid bit, so a line that hit before misses afterwards.
- R11: resp_valid is a single-cycle pulse and is never high together with mem_req_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Cache can accept a request |
| req_vword | input | 10 | Virtual address bits 11:2 (word address within the page) |
| xlat_valid | input | 1 | Translated page number is valid |
| xlat_ppn | input | 20 | Physical page number of the pending request |
| resp_valid | output | 1 | Response strobe |
| resp_data | output | 32 | Requested word |
| mem_req_valid | output | 1 | Line fetch request to next level |
| mem_req_ready | input | 1 | Next level accepts the fetch |
| mem_req_addr | output | 32 | Line-aligned physical address of the fetch |
| fill_valid | input | 1 | Fill beat strobe |
| fill_data | input | 32 | Fill beat data, lowest word first |
| inval_all | input | 1 | Invalidate every line |

## Verification
A wrong internal state shows at the ports in one of two ways. A corrupted tag, valid bit or pseudo-LRU bit changes a hit into a miss or back, and mem_req_valid then appears, or fails to appear, in the cycle after the page number arrives. A wrong word select or beat order gives a resp_data that differs from the address-derived pattern in the response cycle itself. Replacement faults show later, on the first access to a line that should still be resident. The bench therefore fills one set past capacity and probes every survivor. It also holds the translation back, stalls the grant and pokes requests during a fill, so that early or extra pulses show at once.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_MISS_REQ,
        ST_FILL,
        ST_REPLAY
    } vipt_state_e;

endpackage

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       way_valid,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]      ppn,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == ppn);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/vipt_victim_sel.sv
module vipt_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAYS-2:0]  tree,
    output logic [WAY_W-1:0] victim
);

    logic [WAY_W-1:0] tree_way;

    always_comb begin
        int node;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            node = 2 * node + 1 + int'(tree[node]);
        end
        tree_way = WAY_W'(node - (WAYS - 1));
    end

    always_comb begin
        victim = tree_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) victim = WAY_W'(w);
        end
    end

    always_comb begin
        p_invalid_first_r8: assert (&way_valid || !way_valid[victim]);
    end

endmodule

// File: rtl/vipt_plru_update.sv
module vipt_plru_update #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-2:0]  tree,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAYS-2:0]  tree_next
);

    always_comb begin
        int   node;
        logic dir;
        tree_next = tree;
        node      = 0;
        for (int l = 0; l < WAY_W; l++) begin
            dir             = touch_way[WAY_W-1-l];
            tree_next[node] = ~dir;
            node            = 2 * node + 1 + int'(dir);
        end
    end

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_OFF_W = 12,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    localparam int PPN_W   = ADDR_W - PAGE_OFF_W,
    localparam int BYTE_W  = $clog2(WORD_W / 8),
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int IDX_W   = $clog2(SETS),
    localparam int WORDS   = LINE_BYTES * 8 / WORD_W,
    localparam int WSEL_W  = $clog2(WORDS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int LINE_W  = LINE_BYTES * 8,
    localparam int VWORD_W = PAGE_OFF_W - BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VWORD_W-1:0] req_vword,
    input  logic               xlat_valid,
    input  logic [PPN_W-1:0]   xlat_ppn,
    output logic               resp_valid,
    output logic [WORD_W-1:0]  resp_data,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               fill_valid,
    input  logic [WORD_W-1:0]  fill_data,
    input  logic               inval_all
);

    import vipt_pkg::*;

    // Storage: line-wide data entries keep the element count small
    logic [PPN_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-2:0]   plru_q  [SETS];

    vipt_state_e        state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [WSEL_W-1:0]  wsel_q;
    logic [PPN_W-1:0]   ppn_q;
    logic [WAY_W-1:0]   victim_q;
    logic [WSEL_W-1:0]  beat_q;
    logic [LINE_W-1:0]  line_buf_q;
    logic               resp_valid_q;
    logic [WORD_W-1:0]  resp_data_q;

    // Set read from virtual index bits
    logic [WAYS*PPN_W-1:0] set_tags;
    logic [WAYS-1:0]       set_valid;
    logic [WAYS-2:0]       set_tree;
    logic [WAYS-1:0]       hit_vec;
    logic                  hit;
    logic [WAY_W-1:0]      hit_way;
    logic [WAY_W-1:0]      victim;
    logic [WAY_W-1:0]      touch_way;
    logic [WAYS-2:0]       tree_next;
    logic                  lookup_done;
    logic                  last_beat;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w*PPN_W +: PPN_W] = tag_q[idx_q][w];
        end
        set_valid = valid_q[idx_q];
        set_tree  = plru_q[idx_q];
    end

    vipt_tag_match #(.WAYS(WAYS), .TAG_W(PPN_W)) u_match (
        .way_valid (set_valid),
        .way_tags  (set_tags),
        .ppn       (xlat_ppn),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    vipt_victim_sel #(.WAYS(WAYS)) u_victim (
        .way_valid (set_valid),
        .tree      (set_tree),
        .victim    (victim)
    );

    assign touch_way = (state_q == ST_REPLAY) ? victim_q : hit_way;

    vipt_plru_update #(.WAYS(WAYS)) u_plru (
        .tree      (set_tree),
        .touch_way (touch_way),
        .tree_next (tree_next)
    );

    assign lookup_done = (state_q == ST_LOOKUP) && xlat_valid;
    assign last_beat   = fill_valid && (beat_q == WSEL_W'(WORDS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_d = ST_LOOKUP;
            ST_LOOKUP:   if (xlat_valid)    state_d = hit ? ST_IDLE : ST_MISS_REQ;
            ST_MISS_REQ: if (mem_req_ready) state_d = ST_FILL;
            ST_FILL:     if (last_beat)     state_d = ST_REPLAY;
            ST_REPLAY:                      state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // Port outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_MISS_REQ);
        mem_req_addr  = {ppn_q, idx_q, {OFF_W{1'b0}}};
        resp_valid    = resp_valid_q;
        resp_data     = resp_data_q;
    end

    // Request, miss and response datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q        <= '0;
            wsel_q       <= '0;
            ppn_q        <= '0;
            victim_q     <= '0;
            beat_q       <= '0;
            line_buf_q   <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            if (state_q == ST_IDLE && req_valid) begin
                idx_q  <= req_vword[VWORD_W-1 -: IDX_W];
                wsel_q <= req_vword[WSEL_W-1:0];
            end
            if (lookup_done) begin
                ppn_q    <= xlat_ppn;
                victim_q <= victim;
                beat_q   <= '0;
                if (hit) begin
                    resp_valid_q <= 1'b1;
                    resp_data_q  <= data_q[idx_q][hit_way][wsel_q*WORD_W +: WORD_W];
                end
            end
            if (state_q == ST_FILL && fill_valid) begin
                line_buf_q[beat_q*WORD_W +: WORD_W] <= fill_data;
                beat_q <= beat_q + 1'b1;
            end
            if (state_q == ST_REPLAY) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= line_buf_q[wsel_q*WORD_W +: WORD_W];
            end
        end
    end

    // Tag and data arrays: written once the whole line is present
    always_ff @(posedge clk) begin
        if (state_q == ST_REPLAY) begin
            tag_q[idx_q][victim_q]  <= ppn_q;
            data_q[idx_q][victim_q] <= line_buf_q;
        end
    end

    // Valid and replacement state; invalidate-all wins over a fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                plru_q[s]  <= '0;
            end
        end else begin
            if ((lookup_done && hit) || state_q == ST_REPLAY) begin
                plru_q[idx_q] <= tree_next;
            end
            if (state_q == ST_REPLAY) begin
                valid_q[idx_q][victim_q] <= 1'b1;
            end
            if (inval_all) begin
                for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            end
        end
    end

    p_hit_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> $onehot0(hit_vec));

    p_wait_xlat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !xlat_valid) |=> (!resp_valid && !mem_req_valid));

    p_miss_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_miss_after_lookup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(lookup_done));

    p_fill_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && last_beat) |=> resp_valid == 1'b0 ##1 resp_valid);

    p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_resp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && mem_req_valid));

endmodule

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [9:0]  req_vword = '0;
    logic        xlat_valid = 1'b0;
    logic [19:0] xlat_ppn = '0;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic        inval_all = 1'b0;

    always #5 clk = ~clk;

    vipt_cache u_vipt_cache (
        .clk, .rst_n, .req_valid, .req_ready, .req_vword, .xlat_valid, .xlat_ppn,
        .resp_valid, .resp_data, .mem_req_valid, .mem_req_ready, .mem_req_addr,
        .fill_valid, .fill_data, .inval_all
    );

    int n_checks = 0;
    int n_fails  = 0;
    logic [11:0] cur_va  = '0;
    logic [19:0] cur_ppn = '0;
    logic        saw_miss = 1'b0;
    int          grant_delay = 0;

    function automatic logic [31:0] model(input logic [19:0] ppn, input logic [11:0] va, input int k);
        return {ppn, va[11:5], 3'(k), 2'b00} ^ 32'h5A3C_C3A5;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Next-level memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                saw_miss = 1'b1;
                check(mem_req_addr == {cur_ppn, cur_va[11:5], 5'b0}, "R5 line address",
                      mem_req_addr, {cur_ppn, cur_va[11:5], 5'b0});
                for (int d = 0; d < grant_delay; d++) begin
                    @(negedge clk);
                    check(mem_req_valid == 1'b1, "R5 request held", 32'(mem_req_valid), 32'd1);
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int k = 0; k < 8; k++) begin
                    fill_valid = 1'b1;
                    fill_data  = model(cur_ppn, cur_va, k);
                    @(negedge clk);
                end
                fill_valid = 1'b0;
            end
        end
    end

    task automatic access(input logic [11:0] va, input logic [19:0] ppn, input int xlat_delay,
                          input logic poke, input logic exp_hit, input string req);
        int cycles;
        logic [31:0] exp;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_va    = va;
        cur_ppn   = ppn;
        saw_miss  = 1'b0;
        req_valid = 1'b1;
        req_vword = va[11:2];
        @(negedge clk);
        req_valid = 1'b0;
        for (int d = 0; d < xlat_delay; d++) begin
            check(!resp_valid && !mem_req_valid, "R4 no action before page number",
                  {30'b0, resp_valid, mem_req_valid}, 32'd0);
            @(negedge clk);
        end
        xlat_valid = 1'b1;
        xlat_ppn   = ppn;
        @(negedge clk);
        xlat_valid = 1'b0;
        cycles = 0;
        while (!resp_valid && cycles < 200) begin
            check(!req_ready, "R7 ready low while busy", 32'(req_ready), 32'd0);
            if (poke && cycles == 3) begin
                req_valid = 1'b1;
                req_vword = 10'h3F8;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        req_valid = 1'b0;
        exp = model(ppn, va, int'(va[4:2]));
        check(resp_valid, {req, " response seen"}, 32'(resp_valid), 32'd1);
        check(resp_data == exp, {req, " data"}, resp_data, exp);
        check(!saw_miss == exp_hit, {req, " hit/miss"}, 32'(!saw_miss), 32'(exp_hit));
        if (exp_hit) check(cycles == 0, "R3 hit latency", cycles, 32'd0);
        @(negedge clk);
        check(!resp_valid, "R11 single-cycle response", 32'(resp_valid), 32'd0);
    endtask

    // {page offset, ppn, expected hit}
    localparam logic [32:0] VEC [8] = '{
        {12'h124, 20'h12345, 1'b0},
        {12'h13C, 20'h12345, 1'b1},
        {12'h120, 20'h12345, 1'b1},
        {12'h124, 20'h54321, 1'b0},
        {12'hFE0, 20'h00001, 1'b0},
        {12'hFFC, 20'h00001, 1'b1},
        {12'h128, 20'h12345, 1'b1},
        {12'h128, 20'h54321, 1'b1}
    };

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1 no miss after reset", 32'(mem_req_valid), 32'd0);

        // Table walk: R1 first miss, R2 index/word/tag by ppn, R6 fill, R3 hits
        for (int i = 0; i < 8; i++) begin
            access(VEC[i][32:21], VEC[i][20:1], 0, 1'b0, VEC[i][0], "R2 R3 R6 vector");
        end

        // R8: four pages into set 3 take the four invalid ways
        access(12'h064, 20'h0AAAA, 0, 1'b0, 1'b0, "R8 fill A");
        access(12'h064, 20'h0BBBB, 0, 1'b0, 1'b0, "R8 fill B");
        access(12'h064, 20'h0CCCC, 0, 1'b0, 1'b0, "R8 fill C");
        access(12'h064, 20'h0DDDD, 0, 1'b0, 1'b0, "R8 fill D");
        access(12'h064, 20'h0AAAA, 0, 1'b0, 1'b1, "R8 A resident");
        access(12'h064, 20'h0BBBB, 0, 1'b0, 1'b1, "R8 B resident");
        access(12'h064, 20'h0CCCC, 0, 1'b0, 1'b1, "R8 C resident");
        access(12'h064, 20'h0DDDD, 0, 1'b0, 1'b1, "R8 D resident");
        // R9: touch A (way 0), victim becomes way 2 (C)
        access(12'h064, 20'h0AAAA, 0, 1'b0, 1'b1, "R9 touch A");
        access(12'h064, 20'h0EEEE, 0, 1'b0, 1'b0, "R9 fill E");
        access(12'h064, 20'h0BBBB, 0, 1'b0, 1'b1, "R9 B kept");
        access(12'h064, 20'h0DDDD, 0, 1'b0, 1'b1, "R9 D kept");
        access(12'h064, 20'h0AAAA, 0, 1'b0, 1'b1, "R9 A kept");
        access(12'h064, 20'h0EEEE, 0, 1'b0, 1'b1, "R9 E resident");
        access(12'h064, 20'h0CCCC, 0, 1'b0, 1'b0, "R9 C evicted");

        // R4: late page number
        access(12'hFFC, 20'h00001, 3, 1'b0, 1'b1, "R4 late translation");

        // R5 held request, R7 poke ignored during miss
        grant_delay = 2;
        access(12'h0A8, 20'h77777, 0, 1'b1, 1'b0, "R5 R7 stalled miss");
        grant_delay = 0;
        for (int q = 0; q < 6; q++) begin
            check(!resp_valid && !mem_req_valid && req_ready, "R7 poke ignored",
                  {29'b0, resp_valid, mem_req_valid, req_ready}, 32'd1);
            @(negedge clk);
        end

        // R10: invalidate-all
        access(12'h124, 20'h12345, 0, 1'b0, 1'b1, "R10 hit before invalidate");
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        access(12'h124, 20'h12345, 0, 1'b0, 1'b0, "R10 miss after invalidate");
        access(12'hFFC, 20'h00001, 0, 1'b0, 1'b0, "R10 other set also cleared");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule